// File: doc/BRIEF.md
# Transmit Descriptor Walker

This block feeds a transmit FIFO from frames that software has laid out in memory. Each frame is described by one or more descriptors. A descriptor is four 32-bit words at a 16-byte-aligned address. The engine reads a descriptor and checks that the hardware owns it. It then streams that descriptor's buffer, one word per beat, into the FIFO write port. After that it either closes the descriptor or waits for the line side to report how the frame ended. It then writes the result back into memory and steps to the next descriptor, at the next 16-byte slot or back at the ring base.

The engine stops in a suspended state in two cases: when it finds a descriptor that is not owned, and when the line side reports an underflow. The descriptor pointer is kept while suspended, and a single-cycle poll-demand pulse resumes fetching from it. The first poll after reset loads the pointer from the ring base. Five sticky flags report events, and software clears each flag by writing 1 to its bit.

Word 0 bit layout: 31 owned by hardware, 30 interrupt-on-completion, 29 last segment, 25 timestamp request, 21 ring end, 17 timestamp captured, 1 underflow error, 0 error summary. Word 1 bits [15:0] hold the buffer length in 32-bit words. Word 2 holds the buffer byte address. Word 3 is not read.

The memory port has one request channel (valid/ready) and a read-data return that comes at least one cycle after a read request is accepted. The FIFO port is valid/ready. Once a request or a FIFO beat is offered, it stays unchanged until it is accepted, so either side may apply back-pressure for any number of cycles.

Top module: `txdesc_dma`

## Requirements
- R1: After reset the engine is suspended, all five flags are 0, and neither the memory request nor the FIFO valid is asserted.
- R2: Each word of a buffer is pushed into the FIFO in address order, exactly once. The last-flag is set only on the final word of a descriptor whose last-segment bit (bit 29) is 1. A beat that is not accepted is held unchanged.
- R3: Fetching word 0 with bit 31 clear suspends the engine. It sets the buffer-unavailable flag (flags bit 2) together with the normal summary (bit 0), and it leaves the pointer on that descriptor.
- R4: A descriptor that is not the last of its frame gets word 0 written back with only bit 31 cleared. Words 1 to 3 are left untouched.
- R5: The last descriptor of a frame is written back after the line reports completion. Its word 0 has bit 31 cleared and status bits 17, 1 and 0 set from the outcome. All other bits keep their fetched values.
- R6: The timestamp request (bit 25) is taken only from the first descriptor of a frame. Interrupt-on-completion (bit 30) is taken from the last descriptor, and on a good completion it sets the completion flag (bit 4) and the normal summary (bit 0).
- R7: When timestamping is enabled and requested, the value on the timestamp input at completion is written into the last descriptor: low half to word 2, high half to word 3. Bit 17 is set in that descriptor's word 0.
- R8: An underflow report while the engine waits for the line sets bits 1 and 0 in the last descriptor's word 0. It also sets the underflow flag (bit 3) with the abnormal summary (bit 1), suspends the engine, and leaves the pointer on the following descriptor.
- R9: After a descriptor is closed, the pointer advances by 16 bytes, or returns to the ring base if that descriptor's ring-end bit (21) is set.
- R10: A poll pulse while suspended resumes fetching at the held pointer. No memory or FIFO traffic occurs while suspended.
- R11: Writing 1 to a bit of the flag-clear input clears that flag. A 0 leaves it as it is.
- R12: A memory request that is not accepted is held with the same address, direction and write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_base | input | 32 | Ring base byte address (low 4 bits ignored) |
| ts_enable | input | 1 | Global timestamp enable |
| poll_demand | input | 1 | Resume pulse |
| ts_value | input | 64 | Timestamp captured on line_done |
| line_done | input | 1 | Line reports frame sent |
| line_underflow | input | 1 | Line reports FIFO ran empty mid-frame |
| flag_clr | input | 5 | Write-1-to-clear for flags |
| flags | output | 5 | {completion, underflow, buffer-unavailable, abnormal, normal} |
| suspended | output | 1 | Engine idle awaiting poll |
| desc_ptr | output | 32 | Current descriptor address |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 32 | Byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data |
| txf_valid | output | 1 | FIFO beat offered |
| txf_ready | input | 1 | FIFO accepts beat |
| txf_data | output | 32 | FIFO word |
| txf_last | output | 1 | Final word of frame |

## Verification
Flags, the suspended output and the pointer all change at the clock edge where the final word-0 write, or the unowned word-0 read return, is accepted. The bench therefore waits for suspended and samples one falling edge later. FIFO beats are captured at the accepting edge under a ready pattern that stalls. Memory contents are read back only once the engine is suspended, when every write-back has landed. Line reports are driven only after the last beat has been captured, which is the point at which the engine waits for them.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int W0_OWN  = 31;
  localparam int W0_IOC  = 30;
  localparam int W0_LS   = 29;
  localparam int W0_TSE  = 25;
  localparam int W0_RE   = 21;
  localparam int W0_TTSS = 17;
  localparam int W0_UF   = 1;
  localparam int W0_ES   = 0;

  localparam int FL_NIS = 0;
  localparam int FL_AIS = 1;
  localparam int FL_TBU = 2;
  localparam int FL_TU  = 3;
  localparam int FL_TC  = 4;
  localparam int FL_W   = 5;

  typedef enum logic [3:0] {
    S_IDLE, S_RQ0, S_RS0, S_RQ1, S_RS1, S_RQ2, S_RS2,
    S_BRQ, S_BRS, S_PUSH, S_CLOSE, S_WAIT, S_WB2, S_WB3, S_WB0
  } txd_state_t;
endpackage

// File: rtl/txd_ptr.sv
module txd_ptr #(
  parameter int AW = 32,
  parameter int STRIDE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic          load,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] ptr
);
  localparam int SB = $clog2(STRIDE);
  logic [AW-1:0] base_al;

  assign base_al = {base[AW-1:SB], {SB{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (load) ptr <= base_al;
    else if (adv) ptr <= wrap ? base_al : ptr + AW'(STRIDE);
  end
endmodule

// File: rtl/txd_flags.sv
module txd_flags
  import txd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FL_W-1:0] set_ev,
  input  logic [FL_W-1:0] clr,
  output logic [FL_W-1:0] flags
);
  logic [FL_W-1:0] set_all;

  always_comb begin
    set_all = set_ev;
    set_all[FL_NIS] = set_ev[FL_NIS] | set_ev[FL_TBU] | set_ev[FL_TC];
    set_all[FL_AIS] = set_ev[FL_AIS] | set_ev[FL_TU];
  end

  for (genvar b = 0; b < FL_W; b++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else if (set_all[b]) q <= 1'b1;
      else if (clr[b]) q <= 1'b0;
    end
    assign flags[b] = q;
  end
endmodule

// File: rtl/txd_seq.sv
module txd_seq
  import txd_pkg::*;
#(
  parameter int AW = 32,
  parameter int LEN_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            poll,
  input  logic            ts_enable,
  input  logic [63:0]     ts_value,
  input  logic            line_done,
  input  logic            line_underflow,
  input  logic [AW-1:0]   ptr,
  output logic            ptr_load,
  output logic            ptr_adv,
  output logic            ptr_wrap,
  output logic [FL_W-1:0] flag_set,
  output logic            suspended,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [AW-1:0]   mem_req_addr,
  output logic [31:0]     mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [31:0]     mem_rsp_data,
  output logic            txf_valid,
  input  logic            txf_ready,
  output logic [31:0]     txf_data,
  output logic            txf_last
);
  localparam logic [31:0] ST_MASK = (32'd1 << W0_OWN) | (32'd1 << W0_TTSS) |
                                    (32'd1 << W0_UF) | (32'd1 << W0_ES);

  txd_state_t state;
  logic              started;
  logic [31:0]       w0;
  logic [LEN_W-1:0]  blen;
  logic [AW-1:0]     baddr;
  logic [LEN_W-1:0]  widx;
  logic              in_frame;
  logic              stamp;
  logic              err;
  logic [31:0]       data_q;
  logic [63:0]       ts_q;
  logic              last_word;
  logic              req_ok;
  logic [31:0]       wb_word;
  txd_state_t        after_buf;

  assign last_word = (widx == blen - LEN_W'(1));
  assign req_ok    = mem_req_valid && mem_req_ready;
  assign after_buf = w0[W0_LS] ? S_WAIT : S_CLOSE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      started  <= 1'b0;
      w0       <= '0;
      blen     <= '0;
      baddr    <= '0;
      widx     <= '0;
      in_frame <= 1'b0;
      stamp    <= 1'b0;
      err      <= 1'b0;
      data_q   <= '0;
      ts_q     <= '0;
    end else begin
      case (state)
        S_IDLE: if (poll) begin
          state   <= S_RQ0;
          started <= 1'b1;
        end
        S_RQ0: if (mem_req_ready) state <= S_RS0;
        S_RS0: if (mem_rsp_valid) begin
          w0    <= mem_rsp_data;
          state <= mem_rsp_data[W0_OWN] ? S_RQ1 : S_IDLE;
        end
        S_RQ1: if (mem_req_ready) state <= S_RS1;
        S_RS1: if (mem_rsp_valid) begin
          blen  <= mem_rsp_data[LEN_W-1:0];
          state <= S_RQ2;
        end
        S_RQ2: if (mem_req_ready) state <= S_RS2;
        S_RS2: if (mem_rsp_valid) begin
          baddr <= AW'(mem_rsp_data);
          widx  <= '0;
          if (!in_frame) stamp <= w0[W0_TSE] & ts_enable;
          state <= (blen == '0) ? after_buf : S_BRQ;
        end
        S_BRQ: if (mem_req_ready) state <= S_BRS;
        S_BRS: if (mem_rsp_valid) begin
          data_q <= mem_rsp_data;
          state  <= S_PUSH;
        end
        S_PUSH: if (txf_ready) begin
          widx  <= widx + LEN_W'(1);
          state <= last_word ? after_buf : S_BRQ;
        end
        S_CLOSE: if (mem_req_ready) begin
          in_frame <= 1'b1;
          state    <= S_RQ0;
        end
        S_WAIT: begin
          if (line_underflow) begin
            err   <= 1'b1;
            state <= S_WB0;
          end else if (line_done) begin
            err   <= 1'b0;
            ts_q  <= ts_value;
            state <= stamp ? S_WB2 : S_WB0;
          end
        end
        S_WB2: if (mem_req_ready) state <= S_WB3;
        S_WB3: if (mem_req_ready) state <= S_WB0;
        S_WB0: if (mem_req_ready) begin
          in_frame <= 1'b0;
          state    <= err ? S_IDLE : S_RQ0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    wb_word = w0 & ~ST_MASK;
    wb_word[W0_TTSS] = stamp & ~err;
    wb_word[W0_UF]   = err;
    wb_word[W0_ES]   = err;
  end

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = ptr;
    mem_req_wdata = '0;
    case (state)
      S_RQ0: mem_req_valid = 1'b1;
      S_RQ1: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = ptr + AW'(4);
      end
      S_RQ2: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = ptr + AW'(8);
      end
      S_BRQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = baddr + AW'({widx, 2'b00});
      end
      S_CLOSE: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_wdata = w0 & ~(32'd1 << W0_OWN);
      end
      S_WB2: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = ptr + AW'(8);
        mem_req_wdata = ts_q[31:0];
      end
      S_WB3: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = ptr + AW'(12);
        mem_req_wdata = ts_q[63:32];
      end
      S_WB0: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_wdata = wb_word;
      end
      default: ;
    endcase
  end

  assign txf_valid = (state == S_PUSH);
  assign txf_data  = data_q;
  assign txf_last  = (state == S_PUSH) && w0[W0_LS] && last_word;
  assign suspended = (state == S_IDLE);

  assign ptr_load = (state == S_IDLE) && poll && !started;
  assign ptr_adv  = ((state == S_CLOSE) || (state == S_WB0)) && req_ok;
  assign ptr_wrap = w0[W0_RE];

  always_comb begin
    flag_set = '0;
    flag_set[FL_TBU] = (state == S_RS0) && mem_rsp_valid && !mem_rsp_data[W0_OWN];
    flag_set[FL_TU]  = (state == S_WB0) && req_ok && err;
    flag_set[FL_TC]  = (state == S_WB0) && req_ok && !err && w0[W0_IOC];
  end
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
  import txd_pkg::*;
#(
  parameter int AW = 32,
  parameter int LEN_W = 16,
  parameter int DESC_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] desc_base,
  input  logic          ts_enable,
  input  logic          poll_demand,
  input  logic [63:0]   ts_value,
  input  logic          line_done,
  input  logic          line_underflow,
  input  logic [4:0]    flag_clr,
  output logic [4:0]    flags,
  output logic          suspended,
  output logic [AW-1:0] desc_ptr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic          txf_valid,
  input  logic          txf_ready,
  output logic [31:0]   txf_data,
  output logic          txf_last
);
  logic            ptr_load;
  logic            ptr_adv;
  logic            ptr_wrap;
  logic [FL_W-1:0] flag_set;

  txd_ptr #(.AW(AW), .STRIDE(DESC_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .base(desc_base),
    .load(ptr_load), .adv(ptr_adv), .wrap(ptr_wrap), .ptr(desc_ptr)
  );

  txd_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_ev(flag_set), .clr(flag_clr), .flags(flags)
  );

  txd_seq #(.AW(AW), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .poll(poll_demand), .ts_enable(ts_enable),
    .ts_value(ts_value), .line_done(line_done), .line_underflow(line_underflow),
    .ptr(desc_ptr), .ptr_load(ptr_load), .ptr_adv(ptr_adv), .ptr_wrap(ptr_wrap),
    .flag_set(flag_set), .suspended(suspended),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .txf_valid(txf_valid), .txf_ready(txf_ready),
    .txf_data(txf_data), .txf_last(txf_last)
  );
endmodule

// File: rtl/txdesc_dma_chk.sv
module txdesc_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [4:0]    flags,
  input logic          suspended,
  input logic [AW-1:0] desc_ptr,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [AW-1:0] mem_req_addr,
  input logic [31:0]   mem_req_wdata,
  input logic          txf_valid,
  input logic          txf_ready,
  input logic [31:0]   txf_data,
  input logic          txf_last
);
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_write) && $stable(mem_req_wdata));

  a_r2_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    txf_valid && !txf_ready |=> txf_valid && $stable(txf_data) && $stable(txf_last));

  a_r3_tbu_summary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[2]) |-> flags[0]);

  a_r8_tu_summary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[3]) |-> flags[1] && suspended);

  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !mem_req_valid && !txf_valid);

  a_r3_ptr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    suspended && $past(suspended) |-> $stable(desc_ptr));
endmodule

bind txdesc_dma txdesc_dma_chk #(.AW(AW)) u_chk (.*);

// File: tb/txdesc_dma_tb.sv
module txdesc_dma_tb;
  localparam int CLK_NS = 10;
  localparam logic [31:0] BASE = 32'h100;
  // {len[14:11], tse, ioc, uf, exp_flags[7:3], exp_status{ttss,uf,es}[2:0]}
  localparam logic [14:0] VEC [5] = '{
    {4'd3, 1'b1, 1'b1, 1'b0, 5'b10101, 3'b100},
    {4'd1, 1'b0, 1'b0, 1'b0, 5'b00101, 3'b000},
    {4'd4, 1'b1, 1'b1, 1'b1, 5'b01010, 3'b011},
    {4'd2, 1'b0, 1'b1, 1'b0, 5'b10101, 3'b000},
    {4'd5, 1'b1, 1'b0, 1'b0, 5'b00101, 3'b100}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic ts_enable = 1;
  logic poll_demand = 0;
  logic [63:0] ts_value = '0;
  logic line_done = 0;
  logic line_underflow = 0;
  logic [4:0] flag_clr = '0;
  logic [4:0] flags;
  logic suspended;
  logic [31:0] desc_ptr;
  logic mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic txf_valid, txf_ready, txf_last;
  logic [31:0] txf_data;

  logic [31:0] mem [256];
  logic bw_en = 0;
  logic [31:0] bw_addr = '0, bw_data = '0;
  logic [31:0] cyc;
  logic cap_rst = 0;
  logic [31:0] cap [32];
  int cap_n, last_cnt, last_pos;
  logic got_last;
  int n_chk = 0, n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  txdesc_dma u_dut (
    .clk(clk), .rst_n(rst_n), .desc_base(BASE), .ts_enable(ts_enable),
    .poll_demand(poll_demand), .ts_value(ts_value), .line_done(line_done),
    .line_underflow(line_underflow), .flag_clr(flag_clr), .flags(flags),
    .suspended(suspended), .desc_ptr(desc_ptr), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .txf_valid(txf_valid), .txf_ready(txf_ready), .txf_data(txf_data),
    .txf_last(txf_last)
  );

  assign mem_req_ready = (cyc[1:0] != 2'd3);
  assign txf_ready = (cyc % 3 != 0);

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc <= '0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data <= '0;
    end else begin
      cyc <= cyc + 1;
      mem_rsp_valid <= 1'b0;
      if (bw_en) mem[bw_addr[9:2]] <= bw_data;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) mem[mem_req_addr[9:2]] <= mem_req_wdata;
        else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data <= mem[mem_req_addr[9:2]];
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cap_rst || !rst_n) begin
      cap_n <= 0; last_cnt <= 0; last_pos <= -1; got_last <= 1'b0;
    end else if (txf_valid && txf_ready) begin
      cap[cap_n[4:0]] <= txf_data;
      cap_n <= cap_n + 1;
      if (txf_last) begin
        last_cnt <= last_cnt + 1;
        last_pos <= cap_n;
        got_last <= 1'b1;
      end
    end
  end

  task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bw_en = 1; bw_addr = a; bw_data = d;
    @(negedge clk);
    bw_en = 0;
  endtask

  task automatic pulse_poll();
    @(negedge clk); poll_demand = 1;
    @(negedge clk); poll_demand = 0;
  endtask

  task automatic clear_all();
    @(negedge clk); flag_clr = 5'h1F; cap_rst = 1;
    @(negedge clk); flag_clr = 5'h00; cap_rst = 0;
  endtask

  task automatic wait_last(input string tag);
    for (int k = 0; k < 3000 && !got_last; k++) @(negedge clk);
    if (!got_last) check_eq({tag, " timeout waiting last beat"}, 0, 1);
  endtask

  task automatic wait_susp(input string tag);
    for (int k = 0; k < 3000 && !suspended; k++) @(negedge clk);
    if (!suspended) check_eq({tag, " timeout waiting suspend"}, 0, 1);
    @(negedge clk);
  endtask

  task automatic line_report(input bit uf);
    repeat (2) @(negedge clk);
    if (uf) line_underflow = 1; else line_done = 1;
    @(negedge clk);
    line_underflow = 0; line_done = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [14:0] v;
    int slot, nslot, len, bad;
    logic [31:0] da, ba, w0, exp_w0, w2x, w3x;
    logic [63:0] ts;

    for (int k = 0; k < 256; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_eq("R1 suspended at reset", suspended, 1);
    check_eq("R1 flags at reset", flags, 0);
    check_eq("R1 no mem request at reset", mem_req_valid, 0);
    check_eq("R1 no fifo beat at reset", txf_valid, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check_eq("R1 suspended after reset release", suspended, 1);

    // vector table: single-descriptor frames around the ring
    for (int i = 0; i < 5; i++) begin
      v = VEC[i];
      slot = i % 4;
      nslot = (i + 1) % 4;
      len = int'(v[14:11]);
      da = BASE + 32'(16 * slot);
      ba = 32'h200 + 32'(32 * i);
      w0 = (32'd1 << 31) | (32'd1 << 29) | (32'(v[10]) << 25) |
           (32'(v[9]) << 30) | ((slot == 3) ? (32'd1 << 21) : 32'd0);
      ts = 64'h1234_5678_9ABC_0000 + 64'(i);
      wr(da, w0);
      wr(da + 4, 32'(len));
      wr(da + 8, ba);
      wr(da + 12, 32'h0BAD_F00D);
      for (int w = 0; w < len; w++) wr(ba + 32'(4 * w), 32'hA000_0000 | 32'(i << 8) | 32'(w));
      wr(BASE + 32'(16 * nslot), 32'h0);
      clear_all();
      ts_value = ts;
      pulse_poll();
      wait_last($sformatf("R2 vec%0d", i));
      line_report(v[8]);
      wait_susp($sformatf("R10 vec%0d", i));

      check_eq($sformatf("R2 vec%0d beat count", i), cap_n, len);
      bad = 0;
      for (int w = 0; w < len; w++)
        if (cap[w] !== (32'hA000_0000 | 32'(i << 8) | 32'(w))) bad++;
      check_eq($sformatf("R2 vec%0d beat data mismatches", i), bad, 0);
      check_eq($sformatf("R2 vec%0d last flag position", i), last_pos, len - 1);
      check_eq($sformatf("R2 vec%0d last flag count", i), last_cnt, 1);
      exp_w0 = (w0 & ~(32'd1 << 31)) | (32'(v[2]) << 17) | (32'(v[1]) << 1) | 32'(v[0]);
      check_eq($sformatf("R5 R8 vec%0d word0 write-back", i), mem[da[9:2]], exp_w0);
      w2x = v[2] ? ts[31:0] : ba;
      w3x = v[2] ? ts[63:32] : 32'h0BAD_F00D;
      check_eq($sformatf("R7 vec%0d word2", i), mem[da[9:2] + 8'd2], w2x);
      check_eq($sformatf("R7 vec%0d word3", i), mem[da[9:2] + 8'd3], w3x);
      check_eq($sformatf("R3 R6 R8 vec%0d flags", i), flags, v[7:3]);
      check_eq($sformatf("R9 vec%0d pointer", i), desc_ptr, BASE + 32'(16 * nslot));
      check_eq($sformatf("R10 vec%0d suspended", i), suspended, 1);
    end

    // R4 R6: two-descriptor frame at slots 1 and 2
    wr(BASE + 16, (32'd1 << 31) | (32'd1 << 20));
    wr(BASE + 20, 32'd2);
    wr(BASE + 24, 32'h300);
    wr(BASE + 28, 32'h1111_2222);
    wr(BASE + 32, (32'd1 << 31) | (32'd1 << 29) | (32'd1 << 25) | (32'd1 << 30));
    wr(BASE + 36, 32'd1);
    wr(BASE + 40, 32'h320);
    wr(BASE + 44, 32'h3333_4444);
    wr(BASE + 48, 32'h0);
    wr(32'h300, 32'hB000_0000);
    wr(32'h304, 32'hB000_0001);
    wr(32'h320, 32'hB000_0002);
    clear_all();
    ts_value = 64'hFFFF_EEEE_DDDD_CCCC;
    pulse_poll();
    wait_last("R4 multi");
    line_report(1'b0);
    wait_susp("R4 multi");
    check_eq("R2 multi beat count", cap_n, 3);
    check_eq("R2 multi last only on final", last_pos, 2);
    check_eq("R2 multi beat 2 data", cap[2], 32'hB000_0002);
    check_eq("R4 first word0 only owner cleared", mem[(BASE[9:2]) + 8'd4], 32'd1 << 20);
    check_eq("R4 first word1 untouched", mem[(BASE[9:2]) + 8'd5], 32'd2);
    check_eq("R4 first word3 untouched", mem[(BASE[9:2]) + 8'd7], 32'h1111_2222);
    check_eq("R6 last word0 no stamp from last-only request", mem[(BASE[9:2]) + 8'd8],
             (32'd1 << 29) | (32'd1 << 25) | (32'd1 << 30));
    check_eq("R6 last word2 untouched", mem[(BASE[9:2]) + 8'd10], 32'h320);
    check_eq("R6 completion flag from last descriptor", flags, 5'b10101);
    check_eq("R9 multi pointer", desc_ptr, BASE + 48);

    // R11: write-1-to-clear of one flag
    @(negedge clk); flag_clr = 5'b00100;
    @(negedge clk); flag_clr = 5'b00000;
    check_eq("R11 clear only buffer-unavailable", flags, 5'b10001);

    // R3 R10: poll onto a still-unowned descriptor
    clear_all();
    pulse_poll();
    wait_susp("R3 repoll");
    check_eq("R3 repoll flags", flags, 5'b00101);
    check_eq("R3 repoll pointer kept", desc_ptr, BASE + 48);
    check_eq("R10 no beats on repoll", cap_n, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule